// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register Block

This block holds the software-visible control registers of a two-channel IDE bus-master DMA engine. It sits on a simple single-cycle I/O bus and decodes a small window that gives each channel an 8-byte slice. Each slice holds a command byte, a status byte and a 32-bit descriptor-table pointer. The DMA engine reads the start/stop control, the direction and the pointer from the block. It receives a one-cycle abort strobe when software stops a running transfer. It drives the live "active" flag and the one-cycle error and interrupt set pulses that land in the status byte.

Each channel also has a drive interrupt input. That level is passed straight to the channel's legacy interrupt output. It is also copied, one clock later, into a per-channel flag that stands for bit 7 of that channel's configuration-space status byte.

Bus encoding: `bus_size_i` 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Read data is right-aligned and combinational from the selected address. Unused upper bits read as zero. A write takes effect at the clock edge on which `bus_sel_i` and `bus_wr_i` are high.

Top module: `ide_bm_regs`

## Requirements
- R1: After reset, every command, status and descriptor register reads 0, `run_o`, `dir_o`, `abort_o` and `cfg_irq_o` are 0, and `desc_addr_o` is 0.
- R2: Channel n's command byte is at offset n*8, its status byte at n*8+2 and its descriptor pointer at n*8+4..n*8+7. Byte reads at n*8+1 and n*8+3 return 0xFF. Writes there change nothing, and no access to one channel changes the other.
- R3: A byte write to the command offset keeps bit 0 as run (`run_o`) and bit 3 as direction (`dir_o`). All other command bits read back 0.
- R4: A command write that takes run from 1 to 0 makes `abort_o` of that channel high for exactly the one cycle after the write edge.
- R5: Status reads show bit 0 = live `eng_active_i`, bit 1 = error, bit 2 = interrupt and bits 6:5 = stored. Bits 7, 4 and 3 read 0. A byte status write stores bits 6:5 and cannot change bit 0.
- R6: In a status write, a 1 in bit 1 or bit 2 clears that flag, and a 0 leaves it as it was.
- R7: A one-cycle `eng_err_set_i` or `eng_irq_set_i` pulse sets the error or interrupt flag. The pulse wins over a clear write in the same cycle.
- R8: On the command/status offsets (0..3 of a slice), a halfword read returns 0x0000FFFF and a word or reserved-size read returns 0xFFFFFFFF. A write that is not a byte is ignored.
- R9: The descriptor pointer takes byte writes at any of its four offsets (data in bits 7:0), halfword writes at offsets 4 and 6 (data in bits 15:0) and word writes at offset 4. Pointer bits 1:0 always read 0. Reads of the pointer use the same widths and lanes.
- R10: A misaligned halfword or word access, or a reserved-size access, to the pointer is ignored on write and returns all ones for its width on read.
- R11: `legacy_irq_o[n]` equals `drv_irq_i[n]` in the same cycle.
- R12: `cfg_irq_o[n]` (configuration status bit 7) follows `drv_irq_i[n]` one clock later, setting on high and clearing on low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (4) | Byte offset in the window |
| bus_size_i | input | 2 | Access width code |
| bus_wdata_i | input | 32 | Right-aligned write data |
| bus_rdata_o | output | 32 | Right-aligned read data |
| eng_active_i | input | NUM_CH | Engine busy flag per channel |
| eng_err_set_i | input | NUM_CH | Error set pulse per channel |
| eng_irq_set_i | input | NUM_CH | Interrupt set pulse per channel |
| run_o | output | NUM_CH | Start/stop control per channel |
| dir_o | output | NUM_CH | Transfer direction per channel |
| abort_o | output | NUM_CH | One-cycle stop strobe per channel |
| desc_addr_o | output | NUM_CH*32 | Descriptor pointers, channel n in bits n*32 +: 32 |
| drv_irq_i | input | NUM_CH | Drive interrupt level per channel |
| legacy_irq_o | output | NUM_CH | Legacy interrupt per channel |
| cfg_irq_o | output | NUM_CH | Configuration status bit 7 per channel |

## Verification
The bench builds the block with its defaults, NUM_CH = 2, which gives the full 16-byte window with AW = 4. Every slice offset of both channels can be reached, and the bench can show that writes to one channel leave the other untouched. With two channels, the set-versus-clear race and the abort strobe can be driven on one channel while the other sits idle, so cross-channel leakage would show up on the idle channel's status and strobe.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int SLICE_BYTES = 8;
    localparam int DW          = 32;

    typedef struct packed {
        logic        run;
        logic        dir;
        logic [1:0]  st_rw;
        logic        err;
        logic        irq;
        logic [29:0] desc;
        logic        abort;
        logic        cfg_irq;
    } chan_regs_t;
endpackage

// File: rtl/bm_addr_decode.sv
module bm_addr_decode #(
    parameter int NUM_CH = 2,
    parameter int AW     = 4
) (
    input  logic              sel_i,
    input  logic [AW-1:0]     addr_i,
    output logic [NUM_CH-1:0] hit_o,
    output logic [2:0]        off_o
);
    always_comb begin
        off_o = addr_i[2:0];
        for (int n = 0; n < NUM_CH; n++) begin
            hit_o[n] = sel_i && (addr_i[AW-1:3] == (AW-3)'(n));
        end
    end
endmodule

// File: rtl/bm_channel.sv
module bm_channel
    import bm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          wr_i,
    input  logic [2:0]    off_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          eng_active_i,
    input  logic          eng_err_set_i,
    input  logic          eng_irq_set_i,
    input  logic          drv_irq_i,
    output logic          run_o,
    output logic          dir_o,
    output logic          abort_o,
    output logic [DW-1:0] desc_o,
    output logic          cfg_irq_o,
    output logic          err_o,
    output logic          irq_o
);
    chan_regs_t r_d, r_q;

    logic          is_ptr;
    logic          is_byte;
    logic          ptr_ok;
    logic [DW-1:0] ptr_full;
    logic [DW-1:0] ptr_new;
    logic [DW-1:0] ones_w;

    always_comb begin
        is_ptr   = off_i[2];
        is_byte  = (size_i == SZ_BYTE);
        ptr_full = {r_q.desc, 2'b00};
        ptr_ok   = is_byte
                || (size_i == SZ_HALF && !off_i[0])
                || (size_i == SZ_WORD && off_i[1:0] == 2'b00);
        ones_w   = (size_i == SZ_BYTE) ? 32'h0000_00FF :
                   (size_i == SZ_HALF) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

        ptr_new = ptr_full;
        case (size_i)
            SZ_BYTE: ptr_new[8*off_i[1:0] +: 8] = wdata_i[7:0];
            SZ_HALF: ptr_new[16*off_i[1] +: 16] = wdata_i[15:0];
            default: ptr_new = wdata_i;
        endcase

        r_d         = r_q;
        r_d.abort   = 1'b0;
        r_d.cfg_irq = drv_irq_i;

        if (hit_i && wr_i) begin
            if (!is_ptr && is_byte) begin
                if (off_i[1:0] == 2'd0) begin
                    r_d.run   = wdata_i[0];
                    r_d.dir   = wdata_i[3];
                    r_d.abort = r_q.run && !wdata_i[0];
                end else if (off_i[1:0] == 2'd2) begin
                    r_d.st_rw = wdata_i[6:5];
                    if (wdata_i[1]) r_d.err = 1'b0;
                    if (wdata_i[2]) r_d.irq = 1'b0;
                end
            end else if (is_ptr && ptr_ok) begin
                r_d.desc = ptr_new[31:2];
            end
        end

        if (eng_err_set_i) r_d.err = 1'b1;
        if (eng_irq_set_i) r_d.irq = 1'b1;

        rdata_o = '0;
        if (hit_i) begin
            if (!is_ptr) begin
                if (!is_byte) begin
                    rdata_o = ones_w;
                end else begin
                    case (off_i[1:0])
                        2'd0:    rdata_o = {24'd0, 4'd0, r_q.dir, 2'b00, r_q.run};
                        2'd2:    rdata_o = {24'd0, 1'b0, r_q.st_rw, 2'b00,
                                            r_q.irq, r_q.err, eng_active_i};
                        default: rdata_o = 32'h0000_00FF;
                    endcase
                end
            end else if (!ptr_ok) begin
                rdata_o = ones_w;
            end else begin
                case (size_i)
                    SZ_BYTE: rdata_o = {24'd0, ptr_full[8*off_i[1:0] +: 8]};
                    SZ_HALF: rdata_o = {16'd0, ptr_full[16*off_i[1] +: 16]};
                    default: rdata_o = ptr_full;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_o     = r_q.run;
    assign dir_o     = r_q.dir;
    assign abort_o   = r_q.abort;
    assign desc_o    = {r_q.desc, 2'b00};
    assign cfg_irq_o = r_q.cfg_irq;
    assign err_o     = r_q.err;
    assign irq_o     = r_q.irq;
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
    import bm_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int AW     = $clog2(NUM_CH * SLICE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic [1:0]           bus_size_i,
    input  logic [DW-1:0]        bus_wdata_i,
    output logic [DW-1:0]        bus_rdata_o,
    input  logic [NUM_CH-1:0]    eng_active_i,
    input  logic [NUM_CH-1:0]    eng_err_set_i,
    input  logic [NUM_CH-1:0]    eng_irq_set_i,
    output logic [NUM_CH-1:0]    run_o,
    output logic [NUM_CH-1:0]    dir_o,
    output logic [NUM_CH-1:0]    abort_o,
    output logic [NUM_CH*DW-1:0] desc_addr_o,
    input  logic [NUM_CH-1:0]    drv_irq_i,
    output logic [NUM_CH-1:0]    legacy_irq_o,
    output logic [NUM_CH-1:0]    cfg_irq_o
);
    logic [NUM_CH-1:0] ch_hit;
    logic [2:0]        ch_off;
    logic [DW-1:0]     ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_err;
    logic [NUM_CH-1:0] ch_irq;

    bm_addr_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
        .sel_i  (bus_sel_i),
        .addr_i (bus_addr_i),
        .hit_o  (ch_hit),
        .off_o  (ch_off)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        bm_channel u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .hit_i         (ch_hit[n]),
            .wr_i          (bus_wr_i),
            .off_i         (ch_off),
            .size_i        (bus_size_i),
            .wdata_i       (bus_wdata_i),
            .rdata_o       (ch_rdata[n]),
            .eng_active_i  (eng_active_i[n]),
            .eng_err_set_i (eng_err_set_i[n]),
            .eng_irq_set_i (eng_irq_set_i[n]),
            .drv_irq_i     (drv_irq_i[n]),
            .run_o         (run_o[n]),
            .dir_o         (dir_o[n]),
            .abort_o       (abort_o[n]),
            .desc_o        (desc_addr_o[n*DW +: DW]),
            .cfg_irq_o     (cfg_irq_o[n]),
            .err_o         (ch_err[n]),
            .irq_o         (ch_irq[n])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            bus_rdata_o = bus_rdata_o | ch_rdata[n];
        end
    end

    assign legacy_irq_o = drv_irq_i;
endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              addr_b2,
    input logic [1:0]        bus_size_i,
    input logic [31:0]       bus_rdata_o,
    input logic [NUM_CH-1:0] eng_err_set_i,
    input logic [NUM_CH-1:0] eng_irq_set_i,
    input logic [NUM_CH-1:0] run_o,
    input logic [NUM_CH-1:0] abort_o,
    input logic [NUM_CH-1:0] drv_irq_i,
    input logic [NUM_CH-1:0] cfg_irq_o,
    input logic [NUM_CH-1:0] ch_err,
    input logic [NUM_CH-1:0] ch_irq
);
    a_r8_cs_wide_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !addr_b2 && bus_size_i != 2'd0) |->
        bus_rdata_o == ((bus_size_i == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_a
        a_r4_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
            abort_o[n] |=> !abort_o[n]);
        a_r4_abort_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(abort_o[n]) |-> $fell(run_o[n]));
        a_r7_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err_set_i[n] |=> ch_err[n]);
        a_r7_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            eng_irq_set_i[n] |=> ch_irq[n]);
        a_r12_cfg_mirror: assert property (@(posedge clk) disable iff (!rst_n)
            drv_irq_i[n] |=> cfg_irq_o[n]);
        a_r12_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !drv_irq_i[n] |=> !cfg_irq_o[n]);
    end
endmodule

bind ide_bm_regs ide_bm_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel_i     (bus_sel_i),
    .addr_b2       (bus_addr_i[2]),
    .bus_size_i    (bus_size_i),
    .bus_rdata_o   (bus_rdata_o),
    .eng_err_set_i (eng_err_set_i),
    .eng_irq_set_i (eng_irq_set_i),
    .run_o         (run_o),
    .abort_o       (abort_o),
    .drv_irq_i     (drv_irq_i),
    .cfg_irq_o     (cfg_irq_o),
    .ch_err        (ch_err),
    .ch_irq        (ch_irq)
);

// File: tb/ide_bm_regs_tb.sv
module ide_bm_regs_tb;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel = 1'b0, wr = 1'b0;
    logic [3:0]     addr = '0;
    logic [1:0]     size = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] act = '0, eset = '0, iset = '0, drv = '0;
    logic [NCH-1:0] run, dir, abort, leg, cfg;
    logic [63:0]    desc;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ide_bm_regs #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_size_i(size), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .eng_active_i(act), .eng_err_set_i(eset),
        .eng_irq_set_i(iset), .run_o(run), .dir_o(dir), .abort_o(abort),
        .desc_addr_o(desc), .drv_irq_i(drv), .legacy_irq_o(leg),
        .cfg_irq_o(cfg)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bread(input string req, input logic [3:0] a, input logic [1:0] s,
                         input logic [31:0] exp);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; size = s;
        #1;
        check(req, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic t_reset;
        bread("R1 cmd0", 4'h0, 2'd0, 32'h0);
        bread("R1 st1", 4'hA, 2'd0, 32'h0);
        bread("R1 ptr0", 4'h4, 2'd2, 32'h0);
        check("R1 outs", {run, dir, abort, cfg}, 32'h0);
        check("R1 desc", desc[31:0] | desc[63:32], 32'h0);
    endtask

    task automatic t_command;
        bwrite(4'h0, 2'd0, 32'hFF);
        bread("R3 cmd0", 4'h0, 2'd0, 32'h09);
        check("R3 run/dir", {run, dir}, {2'b01, 2'b01});
        check("R2 ch1 cmd untouched", {30'd0, run[1], dir[1]}, 32'h0);
        check("R4 no abort on start", {30'd0, abort}, 32'h0);
        bwrite(4'h0, 2'd2, 32'h0);
        bread("R8 wide write ignored", 4'h0, 2'd0, 32'h09);
        bwrite(4'h0, 2'd0, 32'h08);
        check("R4 abort pulse", {30'd0, abort}, 32'h1);
        @(negedge clk);
        check("R4 abort drops", {30'd0, abort}, 32'h0);
        bread("R3 cmd0 stopped", 4'h0, 2'd0, 32'h08);
    endtask

    task automatic t_status;
        @(negedge clk); eset = 2'b10; iset = 2'b10;
        @(negedge clk); eset = '0; iset = '0;
        bread("R7 flags set", 4'hA, 2'd0, 32'h06);
        act = 2'b10;
        bread("R5 live active", 4'hA, 2'd0, 32'h07);
        bwrite(4'hA, 2'd0, 32'hFF);
        bread("R6 w1c + rw", 4'hA, 2'd0, 32'h61);
        @(negedge clk); iset = 2'b10;
        @(negedge clk); iset = '0;
        bwrite(4'hA, 2'd0, 32'h02);
        bread("R6 zero holds irq", 4'hA, 2'd0, 32'h05);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 4'hA; size = 2'd0; wdata = 32'h04; iset = 2'b10;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; iset = '0;
        bread("R7 set beats clear", 4'hA, 2'd0, 32'h05);
        bwrite(4'hA, 2'd0, 32'h04);
        bread("R6 irq cleared", 4'hA, 2'd0, 32'h01);
        act = '0;
        bread("R2 ch0 status untouched", 4'h2, 2'd0, 32'h00);
    endtask

    task automatic t_map;
        bread("R2 off1", 4'h1, 2'd0, 32'hFF);
        bread("R2 off3", 4'hB, 2'd0, 32'hFF);
        bwrite(4'h1, 2'd0, 32'h00);
        bwrite(4'h3, 2'd0, 32'hFF);
        bread("R2 cmd after off1", 4'h0, 2'd0, 32'h08);
        bread("R2 st after off3", 4'h2, 2'd0, 32'h00);
        bread("R8 half read", 4'h0, 2'd1, 32'h0000FFFF);
        bread("R8 word read", 4'h8, 2'd2, 32'hFFFFFFFF);
    endtask

    task automatic t_pointer;
        bwrite(4'hC, 2'd2, 32'h12345677);
        bread("R9 word ptr1", 4'hC, 2'd2, 32'h12345674);
        check("R9 desc out1", desc[63:32], 32'h12345674);
        bwrite(4'h5, 2'd0, 32'hAB);
        bwrite(4'h6, 2'd1, 32'hCDEF);
        bread("R9 lanes", 4'h4, 2'd2, 32'hCDEFAB00);
        bwrite(4'h4, 2'd0, 32'hFF);
        bread("R9 low bits zero", 4'h4, 2'd2, 32'hCDEFABFC);
        bwrite(4'h5, 2'd1, 32'h1111);
        bwrite(4'h6, 2'd2, 32'h0);
        bwrite(4'h4, 2'd3, 32'h0);
        bread("R10 misaligned writes ignored", 4'h4, 2'd2, 32'hCDEFABFC);
        bread("R10 misaligned word read", 4'h6, 2'd2, 32'hFFFFFFFF);
        bread("R10 misaligned half read", 4'h7, 2'd1, 32'h0000FFFF);
        bread("R9 half read", 4'h6, 2'd1, 32'h0000CDEF);
        bread("R9 byte read", 4'h7, 2'd0, 32'h000000CD);
        check("R2 ptr1 untouched", desc[63:32], 32'h12345674);
    endtask

    task automatic t_irq;
        @(negedge clk); drv = 2'b01;
        #1;
        check("R11 legacy follows", {30'd0, leg}, 32'h1);
        check("R12 cfg not yet", {30'd0, cfg}, 32'h0);
        @(negedge clk);
        check("R12 cfg set", {30'd0, cfg}, 32'h1);
        drv = 2'b10;
        #1;
        check("R11 legacy ch1", {30'd0, leg}, 32'h2);
        @(negedge clk);
        check("R12 cfg swap", {30'd0, cfg}, 32'h2);
        drv = '0;
        @(negedge clk);
        check("R12 cfg cleared", {30'd0, cfg}, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog got=%0d exp=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_command();
        t_status();
        t_map();
        t_pointer();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule